// File: doc/BRIEF.md
# RISC-V Integer Execute Unit

This unit is the arithmetic heart of a single-cycle integer core. It has no clock and no storage. One 3-bit argument-select code picks the pair of operands. The sources are the two register values, a 32-bit immediate, the program counter and the value read from a control/status register. One 4-bit operation code then chooses one of ten arithmetic, logic, shift or compare functions, and the unit returns a 32-bit result and a flag that is high when that result is zero.

The operation code is taken unchanged from instruction bit 30 (code bit 3) and the three-bit function field (code bits 2:0), so the decoder needs no translation table. For the set and clear forms of the status-register instructions, the operand router builds the mask itself. It places the status-register value on the second port and the register or immediate operand on the first port, and it overrides the operation code. The first port always carries the value being shifted.

Immediate extraction, masking of the low bit for indirect jumps, the upper-immediate bypass, register storage and branch decisions belong to neighbouring blocks. The only input this unit gives to a branch decision is the zero flag and bit 0 of a set-less-than result.

Top module: `ex_integer_unit`

## Requirements
- R1: With argument select 000 (port 1 = rs1_val, port 2 = rs2_val), operation code 0000 gives port1 + port2 and 1000 gives port1 - port2, both modulo 2^32.
- R2: Operation code x001 gives port1 shifted left, 0101 a logical right shift and 1101 an arithmetic right shift. The amount is port2[4:0] only, and higher bits of port 2 are ignored.
- R3: Operation code x010 gives 1 when port1 < port2 unsigned and x011 gives 1 when port1 < port2 signed, else 0. Bits 31:1 of the result are always zero, and code bit 3 has no effect.
- R4: Operation codes x100, x110 and x111 give port1 XOR, OR and AND port2 respectively, independent of code bit 3.
- R5: Argument select 001 routes rs1_val to port 1 and imm_val to port 2 under the given operation code. rs2_val has no effect on the result.
- R6: Argument select 010 gives pc_val + imm_val whatever the operation code.
- R7: Argument select 011 gives rs1_val OR csr_val, and select 100 gives imm_val OR csr_val, whatever the operation code.
- R8: Argument select 101 gives (NOT rs1_val) AND csr_val whatever the operation code.
- R9: Argument select 110 gives csr_val AND a mask whose bits 4:0 are NOT imm_val[4:0] and whose bits 31:5 are all ones. Bits 31:5 of csr_val always pass through unchanged.
- R10: Argument select 111 gives a result of zero for any other input values.
- R11: result_zero is 1 exactly when all 32 bits of result are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arg_sel | input | 3 | Operand pair select |
| op_code | input | 4 | Operation: bit 3 from instruction bit 30, bits 2:0 from the function field |
| rs1_val | input | 32 | First register value |
| rs2_val | input | 32 | Second register value |
| imm_val | input | 32 | Extended immediate |
| pc_val | input | 32 | Current program counter |
| csr_val | input | 32 | Status-register read value |
| result | output | 32 | Computed result |
| result_zero | output | 1 | High when result is zero |

## Verification
Every result and the zero flag are purely combinational, so each is due in the same cycle as the inputs that produce it, with zero register stages. The driver applies each stimulus on a falling clock edge and queues the expected result and flag at that moment. The monitor pops and compares on the next rising edge, half a period later. This way every sample is taken on settled values and exactly one expected entry matches each stimulus.

// File: rtl/ex_pkg.sv
package ex_pkg;

  typedef enum logic [2:0] {
    SEL_REG_REG  = 3'b000,
    SEL_REG_IMM  = 3'b001,
    SEL_PC_IMM   = 3'b010,
    SEL_SET_REG  = 3'b011,
    SEL_SET_IMM  = 3'b100,
    SEL_CLR_REG  = 3'b101,
    SEL_CLR_IMM  = 3'b110,
    SEL_NONE     = 3'b111
  } argsel_e;

  typedef enum logic [2:0] {
    F_ADDSUB = 3'b000,
    F_SHL    = 3'b001,
    F_LTU    = 3'b010,
    F_LTS    = 3'b011,
    F_XOR    = 3'b100,
    F_SHR    = 3'b101,
    F_OR     = 3'b110,
    F_AND    = 3'b111
  } func_e;

  localparam logic [3:0] OPC_ADD = 4'b0000;
  localparam logic [3:0] OPC_OR  = 4'b0110;
  localparam logic [3:0] OPC_AND = 4'b0111;

endpackage

// File: rtl/ex_operand_router.sv
module ex_operand_router
  import ex_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int UIMM_W = 5
) (
  input  logic [2:0]      arg_sel,
  input  logic [3:0]      op_in,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] imm_val,
  input  logic [XLEN-1:0] pc_val,
  input  logic [XLEN-1:0] csr_val,
  output logic [XLEN-1:0] port_a,
  output logic [XLEN-1:0] port_b,
  output logic [3:0]      op_out
);

  localparam int HIGH_W = XLEN - UIMM_W;

  logic [XLEN-1:0] clr_imm_mask;

  assign clr_imm_mask = {{HIGH_W{1'b1}}, ~imm_val[UIMM_W-1:0]};

  always_comb begin
    port_a = '0;
    port_b = '0;
    op_out = OPC_ADD;
    case (argsel_e'(arg_sel))
      SEL_REG_REG: begin
        port_a = rs1_val;
        port_b = rs2_val;
        op_out = op_in;
      end
      SEL_REG_IMM: begin
        port_a = rs1_val;
        port_b = imm_val;
        op_out = op_in;
      end
      SEL_PC_IMM: begin
        port_a = pc_val;
        port_b = imm_val;
        op_out = OPC_ADD;
      end
      SEL_SET_REG: begin
        port_a = rs1_val;
        port_b = csr_val;
        op_out = OPC_OR;
      end
      SEL_SET_IMM: begin
        port_a = imm_val;
        port_b = csr_val;
        op_out = OPC_OR;
      end
      SEL_CLR_REG: begin
        port_a = ~rs1_val;
        port_b = csr_val;
        op_out = OPC_AND;
      end
      SEL_CLR_IMM: begin
        port_a = clr_imm_mask;
        port_b = csr_val;
        op_out = OPC_AND;
      end
      default: begin
        port_a = '0;
        port_b = '0;
        op_out = OPC_ADD;
      end
    endcase
  end

endmodule

// File: rtl/ex_alu_core.sv
module ex_alu_core
  import ex_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [3:0]      op,
  output logic [XLEN-1:0] r
);

  localparam int SHAMT_W = $clog2(XLEN);

  logic [SHAMT_W-1:0] shamt;
  logic               lt_u;
  logic               lt_s;
  logic signed [XLEN-1:0] a_s;
  logic [XLEN-1:0]    sra_val;

  assign shamt   = b[SHAMT_W-1:0];
  assign lt_u    = a < b;
  assign lt_s    = $signed(a) < $signed(b);
  assign a_s     = $signed(a);
  assign sra_val = a_s >>> shamt;

  always_comb begin
    case (func_e'(op[2:0]))
      F_ADDSUB: r = op[3] ? (a - b) : (a + b);
      F_SHL:    r = a << shamt;
      F_LTU:    r = {{(XLEN-1){1'b0}}, lt_u};
      F_LTS:    r = {{(XLEN-1){1'b0}}, lt_s};
      F_XOR:    r = a ^ b;
      F_SHR:    r = op[3] ? sra_val : (a >> shamt);
      F_OR:     r = a | b;
      default:  r = a & b;
    endcase
  end

endmodule

// File: rtl/ex_zero_detect.sv
module ex_zero_detect #(
  parameter int XLEN  = 32,
  parameter int GRP_W = 8
) (
  input  logic [XLEN-1:0] value,
  output logic            is_zero
);

  localparam int NGRP = XLEN / GRP_W;

  logic [NGRP-1:0] grp_any;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |value[g*GRP_W +: GRP_W];
  end

  assign is_zero = ~|grp_any;

endmodule

// File: rtl/ex_integer_unit.sv
module ex_integer_unit
  import ex_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int UIMM_W = 5,
  parameter int GRP_W  = 8
) (
  input  logic [2:0]      arg_sel,
  input  logic [3:0]      op_code,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] imm_val,
  input  logic [XLEN-1:0] pc_val,
  input  logic [XLEN-1:0] csr_val,
  output logic [XLEN-1:0] result,
  output logic            result_zero
);

  logic [XLEN-1:0] port_a;
  logic [XLEN-1:0] port_b;
  logic [3:0]      op_eff;

  ex_operand_router #(.XLEN(XLEN), .UIMM_W(UIMM_W)) u_router (
    .arg_sel (arg_sel),
    .op_in   (op_code),
    .rs1_val (rs1_val),
    .rs2_val (rs2_val),
    .imm_val (imm_val),
    .pc_val  (pc_val),
    .csr_val (csr_val),
    .port_a  (port_a),
    .port_b  (port_b),
    .op_out  (op_eff)
  );

  ex_alu_core #(.XLEN(XLEN)) u_alu (
    .a  (port_a),
    .b  (port_b),
    .op (op_eff),
    .r  (result)
  );

  ex_zero_detect #(.XLEN(XLEN), .GRP_W(GRP_W)) u_zero (
    .value   (result),
    .is_zero (result_zero)
  );

  // Checks tying the select code at the ports to the result across all three submodules
  always_comb begin
    if (arg_sel == 3'b111) begin
      a_r10_idle_zero: assert (result == '0 && result_zero);
    end
    if (arg_sel == 3'b010) begin
      a_r6_pc_add: assert (result == pc_val + imm_val);
    end
    if (arg_sel == 3'b110) begin
      a_r9_clear_keeps_high: assert (result[XLEN-1:UIMM_W] == csr_val[XLEN-1:UIMM_W]);
    end
    if (arg_sel == 3'b011) begin
      a_r7_set_superset: assert ((result & csr_val) == csr_val);
    end
    if ((arg_sel == 3'b000 || arg_sel == 3'b001) && op_code[2:1] == 2'b01) begin
      a_r3_slt_narrow: assert (result[XLEN-1:1] == '0);
    end
  end

endmodule

// File: tb/test_ex_integer_unit.sv
module test_ex_integer_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  arg_sel = '0;
  logic [3:0]  op_code = '0;
  logic [31:0] rs1_val = '0, rs2_val = '0, imm_val = '0, pc_val = '0, csr_val = '0;
  logic [31:0] result;
  logic        result_zero;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] q_res[$];
  logic        q_zero[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  ex_integer_unit i_ex_integer_unit (
    .arg_sel, .op_code, .rs1_val, .rs2_val, .imm_val, .pc_val, .csr_val,
    .result, .result_zero
  );

  task automatic apply(input logic [2:0] s, input logic [3:0] o,
                       input logic [31:0] r1, input logic [31:0] r2,
                       input logic [31:0] im, input logic [31:0] p,
                       input logic [31:0] c, input logic [31:0] exp,
                       input string tag);
    @(negedge clk);
    arg_sel = s; op_code = o; rs1_val = r1; rs2_val = r2;
    imm_val = im; pc_val = p; csr_val = c;
    q_res.push_back(exp);
    q_zero.push_back(exp == 32'h0);
    q_tag.push_back(tag);
  endtask

  // Monitor: result is combinational, compared half a period after the stimulus
  always @(posedge clk) begin
    if (!rst && q_res.size() > 0) begin
      logic [31:0] er;
      logic        ez;
      string       t;
      er = q_res.pop_front();
      ez = q_zero.pop_front();
      t  = q_tag.pop_front();
      n_checks++;
      if (result !== er) begin
        n_fail++;
        $display("FAIL %s result actual=%08h expected=%08h", t, result, er);
      end
      n_checks++;
      if (result_zero !== ez) begin
        n_fail++;
        $display("FAIL %s/R11 zero actual=%0b expected=%0b", t, result_zero, ez);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // idle state: all inputs zero
    apply(3'b000, 4'b0000, 0, 0, 0, 0, 0, 32'h0, "R11 idle");
    // R1
    apply(3'b000, 4'b0000, 5, 7, 0, 0, 0, 32'd12, "R1 add");
    apply(3'b000, 4'b1000, 5, 7, 0, 0, 0, 32'hFFFF_FFFE, "R1 sub");
    apply(3'b000, 4'b1000, 32'h1234, 32'h1234, 0, 0, 0, 32'h0, "R1 sub equal");
    // R2
    apply(3'b000, 4'b0001, 1, 32'h23, 0, 0, 0, 32'h8, "R2 sll low5");
    apply(3'b000, 4'b0101, 32'h8000_0000, 4, 0, 0, 0, 32'h0800_0000, "R2 srl");
    apply(3'b000, 4'b1101, 32'h8000_0000, 32'hFFFF_FFE4, 0, 0, 0, 32'hF800_0000, "R2 sra");
    // R3
    apply(3'b000, 4'b0010, 1, 32'hFFFF_FFFF, 0, 0, 0, 32'h1, "R3 sltu");
    apply(3'b000, 4'b0011, 1, 32'hFFFF_FFFF, 0, 0, 0, 32'h0, "R3 slt signed");
    apply(3'b000, 4'b1011, 32'hFFFF_FFFB, 3, 0, 0, 0, 32'h1, "R3 slt bit3");
    // R4
    apply(3'b000, 4'b1100, 32'hF0F0_F0F0, 32'hFF00_FF00, 0, 0, 0, 32'h0FF0_0FF0, "R4 xor");
    apply(3'b000, 4'b0110, 32'hF0F0_0000, 32'h0000_0F0F, 0, 0, 0, 32'hF0F0_0F0F, "R4 or");
    apply(3'b000, 4'b1111, 32'hF0F0_F0F0, 32'hFF00_FF00, 0, 0, 0, 32'hF000_F000, "R4 and");
    // R5
    apply(3'b001, 4'b0000, 100, 32'hDEAD, 32'hFFFF_FFFF, 0, 0, 32'd99, "R5 rs1+imm");
    apply(3'b001, 4'b1101, 32'h8000_0010, 32'h1F, 32'h4, 0, 0, 32'hF800_0001, "R5 srai imm");
    // R6
    apply(3'b010, 4'b1000, 32'h55, 32'h66, 32'hFFFF_FFF0, 32'h1000, 0, 32'h0000_0FF0, "R6 pc+imm");
    // R7
    apply(3'b011, 4'b0000, 32'h0F0, 0, 0, 0, 32'h00F, 32'h0FF, "R7 set reg");
    apply(3'b100, 4'b1000, 32'hFFFF, 0, 32'h15, 0, 32'h100, 32'h115, "R7 set imm");
    // R8
    apply(3'b101, 4'b0000, 32'h0F, 0, 0, 0, 32'hFF, 32'hF0, "R8 clear reg");
    // R9
    apply(3'b110, 4'b0000, 0, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 32'hFFFF_FFE0, "R9 clear imm high");
    apply(3'b110, 4'b0000, 0, 0, 32'h5, 0, 32'h8000_00FF, 32'h8000_00FA, "R9 clear imm");
    // R10
    apply(3'b111, 4'b0110, 32'hFFFF_FFFF, 32'h1, 32'h7, 32'h40, 32'hABCD, 32'h0, "R10 unused sel");
    while (q_res.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule